// File: doc/BRIEF.md
# System MMU Control and Fault Register Block

This block is the software-visible control face of a system MMU. A 32-bit register port lets a driver program the page-directory base, issue commands (turn translation on or off, request and release a stall, flush the translation cache, retire a page fault, return everything to power-on values) and read back a status word describing the paging, stall, fault and idle state. The block also records the address, direction and bus master of the first page fault, and keeps raw, maskable and write-one-to-clear interrupt state that feeds a single interrupt line.

Toward the translation engine the block drives the paging enable, a stall request and the directory base, and it emits one-cycle flush pulses: one for the whole cache and one that carries a single address to evict. The engine returns a stall acknowledge, idle and replay-empty levels, fault reports and read bus-error reports. The page walk itself lives in the engine.

Register reads are combinational on the address; writes take effect at the clock edge where `reg_wen` is high. Offsets: 0x00 directory base, 0x04 status, 0x08 command, 0x0C fault address, 0x10 evict one line, 0x14 raw interrupt, 0x18 interrupt clear, 0x1C interrupt mask, 0x20 masked interrupt, 0x24 clock-gating enable.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset the directory base, paging, stall request, fault state, interrupt state and gating bit are all zero, `irq_o` is low, and the status word reads with bit2 set (stall implied while paging is off) and bit31 clear.
- R2: A write to 0x00 keeps only data bits [31:12]; writing 0xCAFEBABE reads back 0xCAFEB000 and appears on `dir_base_o`.
- R3: A write to 0x08 issues the command in data bits [2:0]: 0 enables paging, 1 disables it (status bit0 and `eng_paging_en` follow); code 7 changes nothing.
- R4: Command 2 raises `eng_stall_req`; status bit2 rises one cycle after the request is seen together with `eng_stall_ack`; command 3 drops the request and bit2 falls one cycle later; bit31 always reads as the inverse of bit2.
- R5: While paging is disabled, status bit2 reads 1 whatever the stall request.
- R6: A fault report taken while paging is on and no fault is pending sets status bit1, stores the address at 0x0C, the write flag in status bit5 and the bus id in status bits [10:6]; reports arriving while a fault is pending or paging is off are dropped.
- R7: Command 2 is ignored while a page fault is pending.
- R8: Command 5 clears status bit1, after which a new fault can be taken.
- R9: Raw interrupt bit0 is set by a taken fault and bit1 by `eng_bus_err`; writing 1 to a bit of 0x18 clears it, and an event in the same cycle wins over the clear.
- R10: Register 0x1C holds the mask, 0x20 reads raw AND mask, and `irq_o` is high exactly when that value is nonzero.
- R11: Command 4 gives a one-cycle `zap_all_o` pulse in the cycle after the write; a write to 0x10 gives a one-cycle `zap_line_o` pulse with `zap_line_addr_o` equal to the written data.
- R12: Command 6 returns the directory base, paging, stall, fault, fault address, interrupt raw and mask state and the gating bit to their reset values.
- R13: Bit0 of 0x24 is read/write and drives `clk_gate_en_o`.
- R14: Status bits 3 and 4 mirror `eng_idle` and `eng_replay_empty`; write-only and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt, OR of masked status |
| dir_base_o | output | 32 | Page-directory base to the engine |
| eng_paging_en | output | 1 | Translation enabled |
| eng_stall_req | output | 1 | Stall request to the engine |
| eng_stall_ack | input | 1 | Engine has no translations outstanding |
| eng_idle | input | 1 | Engine idle level |
| eng_replay_empty | input | 1 | Engine replay buffer empty |
| eng_flt_vld | input | 1 | Page fault report strobe |
| eng_flt_addr | input | 32 | Faulting virtual address |
| eng_flt_write | input | 1 | Faulting access was a write |
| eng_flt_bus_id | input | 5 | Bus id of the faulting master |
| eng_bus_err | input | 1 | Read bus error strobe |
| zap_all_o | output | 1 | Flush whole translation cache, one cycle |
| zap_line_o | output | 1 | Evict one entry, one cycle |
| zap_line_addr_o | output | 32 | Address to evict |
| clk_gate_en_o | output | 1 | Clock-gating enable |

## Verification
The hardest state to reach is a pending fault that must survive competing traffic: a second fault report, a stall request and an interrupt clear arriving while the first fault is still unretired. The stimulus enables paging, injects one fault, then fires further reports and a stall command before retiring it, and repeats this over all 32 bus ids. The same-cycle contest between an interrupt event and its clear is produced by driving the bus-error strobe in the very cycle of a clear write.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_DIR   = 6'h00;
  localparam logic [REG_AW-1:0] OFS_STAT  = 6'h04;
  localparam logic [REG_AW-1:0] OFS_CMD   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_FADDR = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_ZLINE = 6'h10;
  localparam logic [REG_AW-1:0] OFS_RAW   = 6'h14;
  localparam logic [REG_AW-1:0] OFS_CLR   = 6'h18;
  localparam logic [REG_AW-1:0] OFS_MASK  = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_MSTAT = 6'h20;
  localparam logic [REG_AW-1:0] OFS_GATE  = 6'h24;

  typedef enum logic [2:0] {
    CMD_PAGE_ON    = 3'd0,
    CMD_PAGE_OFF   = 3'd1,
    CMD_STALL_ON   = 3'd2,
    CMD_STALL_OFF  = 3'd3,
    CMD_ZAP_ALL    = 3'd4,
    CMD_FAULT_DONE = 3'd5,
    CMD_HARD_RST   = 3'd6,
    CMD_NOP        = 3'd7
  } mmu_cmd_e;

  localparam int ST_PAGING   = 0;
  localparam int ST_FAULT    = 1;
  localparam int ST_STALL    = 2;
  localparam int ST_IDLE     = 3;
  localparam int ST_REPLAY   = 4;
  localparam int ST_FWRITE   = 5;
  localparam int ST_BUSID_LO = 6;
  localparam int ST_NSTALL   = 31;

  localparam int IRQ_FAULT  = 0;
  localparam int IRQ_BUSERR = 1;
  localparam int N_IRQ      = 2;

endpackage

// File: rtl/mmu_ctl_fsm.sv
module mmu_ctl_fsm
  import mmu_ctl_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int BUS_ID_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_vld,
  input  mmu_cmd_e            cmd,
  input  logic                stall_ack,
  input  logic                flt_vld,
  input  logic [VA_W-1:0]     flt_addr,
  input  logic                flt_write,
  input  logic [BUS_ID_W-1:0] flt_bus_id,
  output logic                paging_q,
  output logic                stall_req_q,
  output logic                stall_act_q,
  output logic                flt_act_q,
  output logic [VA_W-1:0]     flt_addr_q,
  output logic                flt_write_q,
  output logic [BUS_ID_W-1:0] flt_bus_q,
  output logic                flt_take
);

  logic                hrst;
  logic                paging_d, stall_req_d, stall_act_d, flt_act_d;
  logic                flt_write_d;
  logic [VA_W-1:0]     flt_addr_d;
  logic [BUS_ID_W-1:0] flt_bus_d;

  assign hrst     = cmd_vld && (cmd == CMD_HARD_RST);
  assign flt_take = flt_vld && paging_q && !flt_act_q && !hrst;

  always_comb begin
    paging_d    = paging_q;
    stall_req_d = stall_req_q;
    stall_act_d = stall_req_q && stall_ack;
    flt_act_d   = flt_act_q;
    flt_addr_d  = flt_addr_q;
    flt_write_d = flt_write_q;
    flt_bus_d   = flt_bus_q;
    if (cmd_vld) begin
      unique case (cmd)
        CMD_PAGE_ON:    paging_d = 1'b1;
        CMD_PAGE_OFF:   paging_d = 1'b0;
        CMD_STALL_ON:   if (!flt_act_q) stall_req_d = 1'b1;
        CMD_STALL_OFF:  stall_req_d = 1'b0;
        CMD_FAULT_DONE: flt_act_d = 1'b0;
        default: ;
      endcase
    end
    if (flt_take) begin
      flt_act_d   = 1'b1;
      flt_addr_d  = flt_addr;
      flt_write_d = flt_write;
      flt_bus_d   = flt_bus_id;
    end
    if (hrst) begin
      paging_d    = 1'b0;
      stall_req_d = 1'b0;
      stall_act_d = 1'b0;
      flt_act_d   = 1'b0;
      flt_addr_d  = '0;
      flt_write_d = 1'b0;
      flt_bus_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paging_q    <= 1'b0;
      stall_req_q <= 1'b0;
      stall_act_q <= 1'b0;
      flt_act_q   <= 1'b0;
      flt_addr_q  <= '0;
      flt_write_q <= 1'b0;
      flt_bus_q   <= '0;
    end else begin
      paging_q    <= paging_d;
      stall_req_q <= stall_req_d;
      stall_act_q <= stall_act_d;
      flt_act_q   <= flt_act_d;
      flt_addr_q  <= flt_addr_d;
      flt_write_q <= flt_write_d;
      flt_bus_q   <= flt_bus_d;
    end
  end

  // R7
  stall_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == CMD_STALL_ON && flt_act_q && !stall_req_q) |=> !stall_req_q);

  // R6
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_act_q && !(cmd_vld && (cmd == CMD_FAULT_DONE || cmd == CMD_HARD_RST)))
      |=> (flt_act_q && $stable(flt_addr_q) && $stable(flt_bus_q)));

  // R4
  stall_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_act_q |-> $past(stall_req_q && stall_ack));

  // R8
  fault_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == CMD_FAULT_DONE) |=> !flt_act_q);

endmodule

// File: rtl/mmu_irq_ctl.sv
module mmu_irq_ctl #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_set,
  input  logic             clr_vld,
  input  logic [N_SRC-1:0] clr_bits,
  input  logic             mask_wr,
  input  logic [N_SRC-1:0] mask_data,
  input  logic             hrst,
  output logic [N_SRC-1:0] raw_q,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] masked,
  output logic             irq
);

  logic [N_SRC-1:0] mask_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic raw_d;
    always_comb begin
      raw_d = raw_q[i];
      if (clr_vld && clr_bits[i]) raw_d = 1'b0;
      if (src_set[i])             raw_d = 1'b1;
      if (hrst)                   raw_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q[i] <= 1'b0;
      else        raw_q[i] <= raw_d;
    end
    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_set[i] && !hrst) |=> raw_q[i]);
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_wr) mask_d = mask_data;
    if (hrst)    mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_ctl_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int BUS_ID_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wen,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq_o,
  output logic [31:0]         dir_base_o,
  output logic                eng_paging_en,
  output logic                eng_stall_req,
  input  logic                eng_stall_ack,
  input  logic                eng_idle,
  input  logic                eng_replay_empty,
  input  logic                eng_flt_vld,
  input  logic [31:0]         eng_flt_addr,
  input  logic                eng_flt_write,
  input  logic [BUS_ID_W-1:0] eng_flt_bus_id,
  input  logic                eng_bus_err,
  output logic                zap_all_o,
  output logic                zap_line_o,
  output logic [31:0]         zap_line_addr_o,
  output logic                clk_gate_en_o
);

  localparam int DIR_W = 32 - PAGE_SHIFT;

  mmu_cmd_e            cmd;
  logic                cmd_vld, hrst;
  logic                stall_act, flt_act, flt_write, flt_take, stall_vis;
  logic [31:0]         flt_addr, status;
  logic [BUS_ID_W-1:0] flt_bus;
  logic [N_IRQ-1:0]    raw, mask, masked, irq_set;
  logic [DIR_W-1:0]    dir_q, dir_d;
  logic                gate_q, gate_d;
  logic                zap_all_d, zap_line_d;
  logic [31:0]         zap_addr_d;

  assign cmd     = mmu_cmd_e'(reg_wdata[2:0]);
  assign cmd_vld = reg_wen && (reg_addr == OFS_CMD);
  assign hrst    = cmd_vld && (cmd == CMD_HARD_RST);

  mmu_ctl_fsm #(.VA_W(32), .BUS_ID_W(BUS_ID_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_vld     (cmd_vld),
    .cmd         (cmd),
    .stall_ack   (eng_stall_ack),
    .flt_vld     (eng_flt_vld),
    .flt_addr    (eng_flt_addr),
    .flt_write   (eng_flt_write),
    .flt_bus_id  (eng_flt_bus_id),
    .paging_q    (eng_paging_en),
    .stall_req_q (eng_stall_req),
    .stall_act_q (stall_act),
    .flt_act_q   (flt_act),
    .flt_addr_q  (flt_addr),
    .flt_write_q (flt_write),
    .flt_bus_q   (flt_bus),
    .flt_take    (flt_take)
  );

  always_comb begin
    irq_set             = '0;
    irq_set[IRQ_FAULT]  = flt_take;
    irq_set[IRQ_BUSERR] = eng_bus_err;
  end

  mmu_irq_ctl #(.N_SRC(N_IRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_set   (irq_set),
    .clr_vld   (reg_wen && reg_addr == OFS_CLR),
    .clr_bits  (reg_wdata[N_IRQ-1:0]),
    .mask_wr   (reg_wen && reg_addr == OFS_MASK),
    .mask_data (reg_wdata[N_IRQ-1:0]),
    .hrst      (hrst),
    .raw_q     (raw),
    .mask_q    (mask),
    .masked    (masked),
    .irq       (irq_o)
  );

  // Local registers: next state
  always_comb begin
    dir_d      = dir_q;
    gate_d     = gate_q;
    zap_all_d  = cmd_vld && (cmd == CMD_ZAP_ALL);
    zap_line_d = reg_wen && (reg_addr == OFS_ZLINE);
    zap_addr_d = zap_line_d ? reg_wdata : zap_line_addr_o;
    if (reg_wen && reg_addr == OFS_DIR)  dir_d  = reg_wdata[31:PAGE_SHIFT];
    if (reg_wen && reg_addr == OFS_GATE) gate_d = reg_wdata[0];
    if (hrst) begin
      dir_d  = '0;
      gate_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q           <= '0;
      gate_q          <= 1'b0;
      zap_all_o       <= 1'b0;
      zap_line_o      <= 1'b0;
      zap_line_addr_o <= '0;
    end else begin
      dir_q           <= dir_d;
      gate_q          <= gate_d;
      zap_all_o       <= zap_all_d;
      zap_line_o      <= zap_line_d;
      zap_line_addr_o <= zap_addr_d;
    end
  end

  assign dir_base_o    = {dir_q, {PAGE_SHIFT{1'b0}}};
  assign clk_gate_en_o = gate_q;

  // Status word and read mux
  assign stall_vis = stall_act || !eng_paging_en;

  always_comb begin
    status                                = '0;
    status[ST_PAGING]                     = eng_paging_en;
    status[ST_FAULT]                      = flt_act;
    status[ST_STALL]                      = stall_vis;
    status[ST_IDLE]                       = eng_idle;
    status[ST_REPLAY]                     = eng_replay_empty;
    status[ST_FWRITE]                     = flt_write;
    status[ST_BUSID_LO +: BUS_ID_W]       = flt_bus;
    status[ST_NSTALL]                     = !stall_vis;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_DIR:   reg_rdata = dir_base_o;
      OFS_STAT:  reg_rdata = status;
      OFS_FADDR: reg_rdata = flt_addr;
      OFS_RAW:   reg_rdata = {{(32-N_IRQ){1'b0}}, raw};
      OFS_MASK:  reg_rdata = {{(32-N_IRQ){1'b0}}, mask};
      OFS_MSTAT: reg_rdata = {{(32-N_IRQ){1'b0}}, masked};
      OFS_GATE:  reg_rdata = {31'b0, gate_q};
      default:   reg_rdata = '0;
    endcase
  end

  // R11
  zap_all_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zap_all_o |-> $past(reg_wen && reg_addr == OFS_CMD && reg_wdata[2:0] == 3'd4));

  // R11
  zap_line_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zap_line_o |-> (zap_line_addr_o == $past(reg_wdata)));

  // R12
  hard_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == OFS_CMD && reg_wdata[2:0] == 3'd6)
      |=> (dir_base_o == '0 && !eng_paging_en && !eng_stall_req && !irq_o && !clk_gate_en_o));

endmodule

// File: tb/tb_mmu_ctl_regs.sv
module tb_mmu_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wen;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_o, eng_paging_en, eng_stall_req, eng_stall_ack;
  logic        eng_idle, eng_replay_empty, eng_flt_vld, eng_flt_write, eng_bus_err;
  logic [31:0] dir_base_o, eng_flt_addr, zap_line_addr_o;
  logic [4:0]  eng_flt_bus_id;
  logic        zap_all_o, zap_line_o, clk_gate_en_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] v, v2;

  always #10 clk = ~clk;

  mmu_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
    .dir_base_o(dir_base_o), .eng_paging_en(eng_paging_en),
    .eng_stall_req(eng_stall_req), .eng_stall_ack(eng_stall_ack),
    .eng_idle(eng_idle), .eng_replay_empty(eng_replay_empty),
    .eng_flt_vld(eng_flt_vld), .eng_flt_addr(eng_flt_addr),
    .eng_flt_write(eng_flt_write), .eng_flt_bus_id(eng_flt_bus_id),
    .eng_bus_err(eng_bus_err), .zap_all_o(zap_all_o), .zap_line_o(zap_line_o),
    .zap_line_addr_o(zap_line_addr_o), .clk_gate_en_o(clk_gate_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] c);
    wr(6'h08, {29'b0, c});
  endtask

  task automatic fault(input logic [31:0] a, input logic w, input logic [4:0] id);
    @(negedge clk);
    eng_flt_vld = 1'b1; eng_flt_addr = a; eng_flt_write = w; eng_flt_bus_id = id;
    @(negedge clk);
    eng_flt_vld = 1'b0;
  endtask

  task automatic berr();
    @(negedge clk);
    eng_bus_err = 1'b1;
    @(negedge clk);
    eng_bus_err = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    eng_stall_ack = 1'b1; eng_idle = 1'b1; eng_replay_empty = 1'b0;
    eng_flt_vld = 1'b0; eng_flt_addr = '0; eng_flt_write = 1'b0;
    eng_flt_bus_id = '0; eng_bus_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state: stall implied (bit2), idle bit3 from input
    rd(6'h04, v); chk("R1 status", v, 32'h0000_000C);
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 dir", dir_base_o, 0);
    chk("R1 paging/stall", {30'b0, eng_paging_en, eng_stall_req}, 0);
    rd(6'h00, v); chk("R1 dir reg", v, 0);

    // R14 mirrors and unmapped/write-only reads
    eng_replay_empty = 1'b1;
    rd(6'h04, v); chk("R14 replay bit4", v & 32'h18, 32'h18);
    eng_idle = 1'b0;
    rd(6'h04, v); chk("R14 idle bit3", v & 32'h18, 32'h10);
    eng_idle = 1'b1;
    for (int a = 0; a < 64; a += 4) begin
      if (a == 8 || a == 16 || a == 24 || a >= 40) begin
        rd(a[5:0], v); chk("R14 zero read", v, 0);
      end
    end

    // R2 directory base truncation
    wr(6'h00, 32'hCAFE_BABE);
    rd(6'h00, v); chk("R2 dir read", v, 32'hCAFE_B000);
    chk("R2 dir out", dir_base_o, 32'hCAFE_B000);
    for (int k = 0; k < 12; k++) begin
      wr(6'h00, 32'h1 << (k + 20));
      rd(6'h00, v); chk("R2 dir bit", v, (32'h1 << (k + 20)) & 32'hFFFF_F000);
    end

    // R3 paging on
    cmd(3'd0);
    chk("R3 paging out", {31'b0, eng_paging_en}, 1);
    rd(6'h04, v); chk("R3 status bit0", v & 32'h1, 1);
    chk("R4 bit31 inverse", {31'b0, v[31]}, {31'b0, ~v[2]});

    // R4 stall handshake timing
    cmd(3'd2);
    chk("R4 stall req", {31'b0, eng_stall_req}, 1);
    rd(6'h04, v); chk("R4 bit2 not yet", {31'b0, v[2]}, 0);
    @(negedge clk);
    rd(6'h04, v); chk("R4 bit2 set", {30'b0, v[31], v[2]}, 2'b01);
    cmd(3'd3);
    chk("R4 stall req drop", {31'b0, eng_stall_req}, 0);
    @(negedge clk);
    rd(6'h04, v); chk("R4 bit2 clear", {30'b0, v[31], v[2]}, 2'b10);
    // R4 no ack: request stays, bit2 stays low
    eng_stall_ack = 1'b0;
    cmd(3'd2);
    repeat (3) @(negedge clk);
    rd(6'h04, v); chk("R4 no ack", {30'b0, eng_stall_req, v[2]}, 2'b10);
    cmd(3'd3);
    eng_stall_ack = 1'b1;

    // R5 paging off implies stall
    cmd(3'd1);
    chk("R3 paging off", {31'b0, eng_paging_en}, 0);
    rd(6'h04, v); chk("R5 stall implied", {30'b0, v[31], v[2]}, 2'b01);

    // R6 fault dropped while paging off
    fault(32'h1234_5000, 1'b1, 5'd9);
    rd(6'h04, v); chk("R6 off no fault", v & 32'h7E2, 0);
    rd(6'h14, v); chk("R6 off no raw", v, 0);

    // R6/R8 sweep of bus ids with competing traffic
    cmd(3'd0);
    for (int id = 0; id < 32; id++) begin
      logic [31:0] fa;
      fa = 32'h1000_0000 + id * 32'h0001_1003;
      fault(fa, id[0], id[4:0]);
      rd(6'h04, v);
      chk("R6 fault bit1", {31'b0, v[1]}, 1);
      chk("R6 write bit5", {31'b0, v[5]}, {31'b0, id[0]});
      chk("R6 bus id", {27'b0, v[10:6]}, id);
      rd(6'h0C, v); chk("R6 fault addr", v, fa);
      fault(~fa, ~id[0], ~id[4:0]);
      rd(6'h0C, v); chk("R6 second dropped", v, fa);
      rd(6'h04, v2); chk("R6 id kept", {27'b0, v2[10:6]}, id);
      // R7 stall refused while fault pending
      cmd(3'd2);
      chk("R7 stall refused", {31'b0, eng_stall_req}, 0);
      cmd(3'd5);
      rd(6'h04, v); chk("R8 fault cleared", {31'b0, v[1]}, 0);
      wr(6'h18, 32'h1);
    end
    cmd(3'd2);
    chk("R7 stall after done", {31'b0, eng_stall_req}, 1);
    cmd(3'd3);

    // R9/R10 sweep raw x mask
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < 4; m++) begin
        wr(6'h18, 32'h3);
        wr(6'h1C, m);
        if (r[0]) begin fault(32'hABC0_0000, 1'b0, 5'd1); cmd(3'd5); end
        if (r[1]) berr();
        rd(6'h14, v); chk("R9 raw", v, r);
        rd(6'h1C, v); chk("R10 mask", v, m);
        rd(6'h20, v); chk("R10 masked", v, r & m);
        chk("R10 irq", {31'b0, irq_o}, {31'b0, |(r[1:0] & m[1:0])});
      end
    end

    // R9 event wins over same-cycle clear
    wr(6'h18, 32'h3);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 6'h18; reg_wdata = 32'h2; eng_bus_err = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; eng_bus_err = 1'b0;
    rd(6'h14, v); chk("R9 set wins", v, 32'h2);
    wr(6'h18, 32'h2);
    rd(6'h14, v); chk("R9 clear", v, 0);

    // R11 flush pulses
    cmd(3'd4);
    chk("R11 zap all pulse", {31'b0, zap_all_o}, 1);
    @(negedge clk);
    chk("R11 zap all end", {31'b0, zap_all_o}, 0);
    wr(6'h10, 32'hDEAD_1000);
    chk("R11 zap line pulse", {31'b0, zap_line_o}, 1);
    chk("R11 zap line addr", zap_line_addr_o, 32'hDEAD_1000);
    @(negedge clk);
    chk("R11 zap line end", {30'b0, zap_line_o, zap_all_o}, 0);

    // R13 gating bit
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, v); chk("R13 gate read", v, 1);
    chk("R13 gate out", {31'b0, clk_gate_en_o}, 1);

    // R3 code 7 ignored
    rd(6'h04, v2);
    cmd(3'd7);
    rd(6'h04, v); chk("R3 nop status", v, v2);

    // R12 hard reset
    wr(6'h00, 32'h8765_4321);
    wr(6'h1C, 32'h3);
    fault(32'h5555_0000, 1'b1, 5'd17);
    cmd(3'd2);
    chk("R12 pre irq", {31'b0, irq_o}, 1);
    cmd(3'd6);
    chk("R12 dir out", dir_base_o, 0);
    rd(6'h00, v); chk("R12 dir reg", v, 0);
    rd(6'h04, v); chk("R12 status", v, 32'h0000_001C);
    rd(6'h0C, v); chk("R12 fault addr", v, 0);
    rd(6'h14, v); chk("R12 raw", v, 0);
    rd(6'h1C, v); chk("R12 mask", v, 0);
    chk("R12 outs", {28'b0, irq_o, eng_paging_en, eng_stall_req, clk_gate_en_o}, 0);

    finish_run();
  end

endmodule